// File: doc/BRIEF.md
# Compressed Instruction Expander for Packet-Forwarding Code

This block turns a 16-bit instruction parcel into the 32-bit RV32I instruction it stands for. It is purely combinational and sits between the fetch aligner and the decoder of a small core. The aligner presents each parcel with a valid bit, and the decoder only ever sees full-width base instructions. A flag tells it whether the parcel was a short form. A second flag raises an illegal-instruction exception.

The short-form opcode map is tuned for packet-forwarding code. None of the floating-point short forms remain. Their slots now hold:
- byte and halfword loads and stores;
- stack-pointer-relative byte and halfword variants;
- an AND-immediate in quadrant 0.

The rest of the map keeps the usual base-ISA short forms. Several forms name the zero register, the link register or the stack pointer without encoding them. Short register fields reach only x8..x15.

A parcel whose two low bits are 11 starts a full-length instruction. That parcel is passed straight through.

Top module: `cx_expander`

## Requirements
- R1: With valid_i low, instr_o is 32'h00000013, and compressed_o and illegal_o are both 0, whatever the parcel holds.
- R2: With valid_i high and parcel bits [1:0] = 11, instr_o equals {16'h0000, parcel}, compressed_o is 0 and illegal_o is 0.
- R3: With valid_i high and bits [1:0] other than 11, compressed_o is 1. Every illegal parcel outputs instr_o = 32'h00000013 with illegal_o = 1. The all-zero parcel is illegal.
- R4: A 3-bit register field holding value n names register x(8+n).
- R5: Quadrant 00, slot 000 expands to addi rd', x2, imm. The imm is {p[10:7], p[12:11], p[5], p[6], 2'b00}, with rd' in p[4:2]. An imm of zero is illegal.
- R6: Quadrant 00, slots 010 and 110 (lw and sw) use base rs1' in p[9:7] and data register rd'/rs2' in p[4:2]. Their offset is {p[5], p[12:10], p[6], 2'b00}.
- R7: Quadrant 00, slots 001 (lbu), 101 (sb) and 011 (sh) use the same register fields. Their base offset is {p[5], p[12:10], p[6]}, counted in bytes. For sh this offset is doubled.
- R8: Quadrant 00, slot 111 expands to andi r', r', sext({p[12], p[6:2]}), with r' in p[9:7]. Bits p[11:10] are ignored.
- R9: Slot 100 of quadrant 00 and slot 111 of quadrant 10 are reserved and illegal.
- R10: In quadrant 01, slot 000 gives addi rd, rd, imm6 and slot 010 gives addi rd, x0, imm6. Slot 011 gives addi x2, x2, {p12, p4:3, p5, p2, p6, 0000} when rd = 2, and lui rd, sext(imm6) otherwise. Here imm6 = {p12, p6:2}, and a zero immediate in slot 011 is illegal.
- R11: In quadrant 01, slots 001 and 101 give jal x1 and jal x0. Their offset is {p12, p8, p10:9, p6, p7, p2, p11, p5:3, 0}. Slots 110 and 111 give beq and bne of rs1' against x0, with offset {p12, p6:5, p2, p11:10, p4:3, 0}.
- R12: In quadrant 01, slot 100 selects on p[11:10]: 00 srli, 01 srai, 10 andi, 11 register ALU. The register ALU op is picked by p[6:5] (00 sub, 01 xor, 10 or, 11 and). A shift amount with p[12] = 1 is illegal, and so is the register ALU group with p[12] = 1.
- R13: In quadrant 10, the stack forms use x2 as base.
  - slli (000): a shift with p[12] = 1 is illegal.
  - lw (010): offset {p3:2, p12, p6:4, 00}.
  - lbu (001): offset {p3:2, p12, p6:4}.
  - sw (110): offset {p8:7, p12:9, 00}, with the data register in p[6:2].
  - sh (011): offset {p8:7, p12:9, 0}, with the data register in p[6:2].
  - sb (101): offset {p8:7, p12:9}, with the data register in p[6:2].
  - A stack load whose destination is x0 is illegal.
- R14: In quadrant 10, slot 100 holds five forms:
  - p12 = 0 with rs2 = 0 gives jalr x0, 0(rs1); rs1 = 0 here is illegal.
  - p12 = 0 with rs2 ≠ 0 gives add rd, x0, rs2.
  - p12 = 1 with both fields zero gives ebreak (32'h00100073).
  - p12 = 1 with only rs2 zero gives jalr x1, 0(rs1).
  - Any other case gives add rd, rd, rs2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| parcel_i | input | 16 | Instruction parcel from the fetch aligner |
| valid_i | input | 1 | Parcel is meaningful this cycle |
| instr_o | output | 32 | Expanded or passed-through instruction |
| compressed_o | output | 1 | Parcel was a short form |
| illegal_o | output | 1 | Parcel is not a legal short form |

## Verification
The block holds no state, so any wrong internal decision is visible at instr_o in the same cycle the parcel is presented. A mis-sliced immediate bit shows up as a wrong offset or immediate field in the expanded word. A wrong register mapping shows up as a wrong register number. A missed reserved case shows up as a non-NOP word with the illegal flag low. The directed cases therefore pick each immediate field with distinct bit patterns, including all-ones and single-bit values. This lets a swapped or dropped bit move exactly one field of the expected word.

// File: rtl/cx_pkg.sv
`timescale 1ns/1ps
package cx_pkg;
  localparam int PARCEL_W = 16;
  localparam int INSTR_W  = 32;
  localparam int REG_W    = 5;
  localparam int PRIME_W  = 3;

  typedef logic [INSTR_W-1:0] instr_t;
  typedef logic [REG_W-1:0]   reg_t;

  localparam logic [6:0] OP_LOAD   = 7'h03;
  localparam logic [6:0] OP_IMM    = 7'h13;
  localparam logic [6:0] OP_STORE  = 7'h23;
  localparam logic [6:0] OP_REG    = 7'h33;
  localparam logic [6:0] OP_LUI    = 7'h37;
  localparam logic [6:0] OP_BRANCH = 7'h63;
  localparam logic [6:0] OP_JALR   = 7'h67;
  localparam logic [6:0] OP_JAL    = 7'h6F;

  localparam instr_t INSTR_NOP    = 32'h0000_0013;
  localparam instr_t INSTR_EBREAK = 32'h0010_0073;

  localparam reg_t R_ZERO = 5'd0;
  localparam reg_t R_LINK = 5'd1;
  localparam reg_t R_SP   = 5'd2;

  // short register field -> x8..x15
  function automatic reg_t prime_reg(input logic [PRIME_W-1:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [11:0] sext6(input logic [5:0] v);
    return {{6{v[5]}}, v};
  endfunction

  function automatic instr_t enc_i(input logic [11:0] imm, input reg_t rs1,
                                   input logic [2:0] f3, input reg_t rd,
                                   input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic instr_t enc_s(input logic [11:0] imm, input reg_t rs2,
                                   input reg_t rs1, input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OP_STORE};
  endfunction

  function automatic instr_t enc_r(input logic [6:0] f7, input reg_t rs2,
                                   input reg_t rs1, input logic [2:0] f3,
                                   input reg_t rd);
    return {f7, rs2, rs1, f3, rd, OP_REG};
  endfunction

  function automatic instr_t enc_b(input logic [12:0] off, input reg_t rs1,
                                   input logic [2:0] f3);
    return {off[12], off[10:5], R_ZERO, rs1, f3, off[4:1], off[11], OP_BRANCH};
  endfunction

  function automatic instr_t enc_j(input logic [20:0] off, input reg_t rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, OP_JAL};
  endfunction
endpackage

// File: rtl/cx_quad0.sv
`timescale 1ns/1ps
module cx_quad0 import cx_pkg::*; (
  input  logic [15:0] parcel_i,
  output logic        hit_o,
  output instr_t      instr_o,
  output logic        illegal_o
);
  logic [2:0] slot;
  reg_t       r_low, r_mid;
  logic [9:0] spn_imm;
  logic [6:0] word_off;
  logic [4:0] byte_off;
  instr_t     raw;
  logic       bad;

  assign hit_o    = (parcel_i[1:0] == 2'b00);
  assign slot     = parcel_i[15:13];
  assign r_low    = prime_reg(parcel_i[4:2]);
  assign r_mid    = prime_reg(parcel_i[9:7]);
  assign spn_imm  = {parcel_i[10:7], parcel_i[12:11], parcel_i[5], parcel_i[6], 2'b00};
  assign byte_off = {parcel_i[5], parcel_i[12:10], parcel_i[6]};
  assign word_off = {byte_off, 2'b00};

  always_comb begin
    raw = INSTR_NOP;
    bad = 1'b0;
    case (slot)
      3'b000: begin
        raw = enc_i({2'b00, spn_imm}, R_SP, 3'b000, r_low, OP_IMM);
        bad = (spn_imm == 10'd0);
      end
      3'b001: raw = enc_i({7'd0, byte_off}, r_mid, 3'b100, r_low, OP_LOAD);
      3'b010: raw = enc_i({5'd0, word_off}, r_mid, 3'b010, r_low, OP_LOAD);
      3'b011: raw = enc_s({6'd0, byte_off, 1'b0}, r_low, r_mid, 3'b001);
      3'b100: bad = 1'b1;
      3'b101: raw = enc_s({7'd0, byte_off}, r_low, r_mid, 3'b000);
      3'b110: raw = enc_s({5'd0, word_off}, r_low, r_mid, 3'b010);
      default: raw = enc_i(sext6({parcel_i[12], parcel_i[6:2]}), r_mid, 3'b111, r_mid, OP_IMM);
    endcase
  end

  assign instr_o   = bad ? INSTR_NOP : raw;
  assign illegal_o = bad;

  always_comb begin
    if (slot == 3'b100)
      a_r9_q0_reserved: assert (illegal_o) else $error("R9 quadrant 0 reserved slot accepted");
    if (!illegal_o)
      a_r4_q0_base_reg: assert (instr_o[19:18] == 2'b01 || instr_o[19:15] == R_SP)
        else $error("R4 quadrant 0 base register outside x8..x15 and not sp");
  end
endmodule

// File: rtl/cx_quad1.sv
`timescale 1ns/1ps
module cx_quad1 import cx_pkg::*; (
  input  logic [15:0] parcel_i,
  output logic        hit_o,
  output instr_t      instr_o,
  output logic        illegal_o
);
  logic [2:0]  slot;
  reg_t        rd, r_mid, r_low;
  logic [5:0]  imm6;
  logic [11:0] imm12;
  logic [11:0] jmp_off;
  logic [8:0]  br_off;
  logic [9:0]  sp_adj;
  instr_t      raw;
  logic        bad;

  assign hit_o   = (parcel_i[1:0] == 2'b01);
  assign slot    = parcel_i[15:13];
  assign rd      = parcel_i[11:7];
  assign r_mid   = prime_reg(parcel_i[9:7]);
  assign r_low   = prime_reg(parcel_i[4:2]);
  assign imm6    = {parcel_i[12], parcel_i[6:2]};
  assign imm12   = sext6(imm6);
  assign jmp_off = {parcel_i[12], parcel_i[8], parcel_i[10:9], parcel_i[6], parcel_i[7],
                    parcel_i[2], parcel_i[11], parcel_i[5:3], 1'b0};
  assign br_off  = {parcel_i[12], parcel_i[6:5], parcel_i[2], parcel_i[11:10],
                    parcel_i[4:3], 1'b0};
  assign sp_adj  = {parcel_i[12], parcel_i[4:3], parcel_i[5], parcel_i[2], parcel_i[6], 4'b0000};

  always_comb begin
    raw = INSTR_NOP;
    bad = 1'b0;
    case (slot)
      3'b000: raw = enc_i(imm12, rd, 3'b000, rd, OP_IMM);
      3'b001: raw = enc_j({{9{jmp_off[11]}}, jmp_off}, R_LINK);
      3'b010: raw = enc_i(imm12, R_ZERO, 3'b000, rd, OP_IMM);
      3'b011: begin
        bad = (imm6 == 6'd0);
        if (rd == R_SP) raw = enc_i({{2{sp_adj[9]}}, sp_adj}, R_SP, 3'b000, R_SP, OP_IMM);
        else            raw = {{14{imm6[5]}}, imm6, rd, OP_LUI};
      end
      3'b100: begin
        case (parcel_i[11:10])
          2'b00: begin
            raw = enc_i({7'd0, parcel_i[6:2]}, r_mid, 3'b101, r_mid, OP_IMM);
            bad = parcel_i[12];
          end
          2'b01: begin
            raw = enc_i({7'b0100000, parcel_i[6:2]}, r_mid, 3'b101, r_mid, OP_IMM);
            bad = parcel_i[12];
          end
          2'b10: raw = enc_i(imm12, r_mid, 3'b111, r_mid, OP_IMM);
          default: begin
            bad = parcel_i[12];
            case (parcel_i[6:5])
              2'b00:   raw = enc_r(7'b0100000, r_low, r_mid, 3'b000, r_mid);
              2'b01:   raw = enc_r(7'd0, r_low, r_mid, 3'b100, r_mid);
              2'b10:   raw = enc_r(7'd0, r_low, r_mid, 3'b110, r_mid);
              default: raw = enc_r(7'd0, r_low, r_mid, 3'b111, r_mid);
            endcase
          end
        endcase
      end
      3'b101: raw = enc_j({{9{jmp_off[11]}}, jmp_off}, R_ZERO);
      3'b110: raw = enc_b({{4{br_off[8]}}, br_off}, r_mid, 3'b000);
      default: raw = enc_b({{4{br_off[8]}}, br_off}, r_mid, 3'b001);
    endcase
  end

  assign instr_o   = bad ? INSTR_NOP : raw;
  assign illegal_o = bad;

  always_comb begin
    if (slot == 3'b011 && parcel_i[12] == 1'b0 && parcel_i[6:2] == 5'd0)
      a_r10_zero_upper: assert (illegal_o) else $error("R10 zero immediate accepted");
    if (!illegal_o && (slot == 3'b110 || slot == 3'b111))
      a_r11_branch_zero: assert (instr_o[24:20] == R_ZERO && instr_o[19:18] == 2'b01)
        else $error("R11 branch operands wrong");
  end
endmodule

// File: rtl/cx_quad2.sv
`timescale 1ns/1ps
module cx_quad2 import cx_pkg::*; (
  input  logic [15:0] parcel_i,
  output logic        hit_o,
  output instr_t      instr_o,
  output logic        illegal_o
);
  logic [2:0] slot;
  reg_t       rd, rs2;
  logic [5:0] ld_units;
  logic [5:0] st_units;
  instr_t     raw;
  logic       bad;

  assign hit_o    = (parcel_i[1:0] == 2'b10);
  assign slot     = parcel_i[15:13];
  assign rd       = parcel_i[11:7];
  assign rs2      = parcel_i[6:2];
  assign ld_units = {parcel_i[3:2], parcel_i[12], parcel_i[6:4]};
  assign st_units = {parcel_i[8:7], parcel_i[12:9]};

  always_comb begin
    raw = INSTR_NOP;
    bad = 1'b0;
    case (slot)
      3'b000: begin
        raw = enc_i({7'd0, rs2}, rd, 3'b001, rd, OP_IMM);
        bad = parcel_i[12];
      end
      3'b001: begin
        raw = enc_i({6'd0, ld_units}, R_SP, 3'b100, rd, OP_LOAD);
        bad = (rd == R_ZERO);
      end
      3'b010: begin
        raw = enc_i({4'd0, ld_units, 2'b00}, R_SP, 3'b010, rd, OP_LOAD);
        bad = (rd == R_ZERO);
      end
      3'b011: raw = enc_s({5'd0, st_units, 1'b0}, rs2, R_SP, 3'b001);
      3'b100: begin
        if (!parcel_i[12]) begin
          if (rs2 == R_ZERO) begin
            raw = enc_i(12'd0, rd, 3'b000, R_ZERO, OP_JALR);
            bad = (rd == R_ZERO);
          end else begin
            raw = enc_r(7'd0, rs2, R_ZERO, 3'b000, rd);
          end
        end else if (rs2 == R_ZERO) begin
          if (rd == R_ZERO) raw = INSTR_EBREAK;
          else              raw = enc_i(12'd0, rd, 3'b000, R_LINK, OP_JALR);
        end else begin
          raw = enc_r(7'd0, rs2, rd, 3'b000, rd);
        end
      end
      3'b101: raw = enc_s({6'd0, st_units}, rs2, R_SP, 3'b000);
      3'b110: raw = enc_s({4'd0, st_units, 2'b00}, rs2, R_SP, 3'b010);
      default: bad = 1'b1;
    endcase
  end

  assign instr_o   = bad ? INSTR_NOP : raw;
  assign illegal_o = bad;

  always_comb begin
    if (slot == 3'b111)
      a_r9_q2_reserved: assert (illegal_o) else $error("R9 quadrant 2 reserved slot accepted");
    if (!illegal_o && (slot == 3'b001 || slot == 3'b010 || slot == 3'b011 ||
                       slot == 3'b101 || slot == 3'b110))
      a_r13_sp_base: assert (instr_o[19:15] == R_SP) else $error("R13 stack form not based on sp");
  end
endmodule

// File: rtl/cx_expander.sv
`timescale 1ns/1ps
module cx_expander import cx_pkg::*; (
  input  logic [15:0] parcel_i,
  input  logic        valid_i,
  output logic [31:0] instr_o,
  output logic        compressed_o,
  output logic        illegal_o
);
  logic   hit0, hit1, hit2, full_len;
  instr_t ins0, ins1, ins2;
  logic   bad0, bad1, bad2;

  cx_quad0 u_quad0 (.parcel_i(parcel_i), .hit_o(hit0), .instr_o(ins0), .illegal_o(bad0));
  cx_quad1 u_quad1 (.parcel_i(parcel_i), .hit_o(hit1), .instr_o(ins1), .illegal_o(bad1));
  cx_quad2 u_quad2 (.parcel_i(parcel_i), .hit_o(hit2), .instr_o(ins2), .illegal_o(bad2));

  assign full_len = (parcel_i[1:0] == 2'b11);

  always_comb begin
    instr_o      = INSTR_NOP;
    compressed_o = 1'b0;
    illegal_o    = 1'b0;
    if (valid_i) begin
      if (full_len) begin
        instr_o = {{(INSTR_W-PARCEL_W){1'b0}}, parcel_i};
      end else begin
        compressed_o = 1'b1;
        if (hit0)      begin instr_o = ins0; illegal_o = bad0; end
        else if (hit1) begin instr_o = ins1; illegal_o = bad1; end
        else if (hit2) begin instr_o = ins2; illegal_o = bad2; end
      end
    end
  end

  always_comb begin
    if (!valid_i)
      a_r1_idle_quiet: assert (!illegal_o && !compressed_o && instr_o == INSTR_NOP)
        else $error("R1 outputs active without valid");
    if (valid_i && full_len)
      a_r2_pass_through: assert (instr_o[15:0] == parcel_i && !compressed_o && !illegal_o)
        else $error("R2 full-length parcel altered");
    if (illegal_o)
      a_r3_illegal_nop: assert (instr_o == INSTR_NOP && compressed_o)
        else $error("R3 illegal parcel produced non-NOP");
    if (compressed_o)
      a_r3_full_width: assert (instr_o[1:0] == 2'b11)
        else $error("R3 expansion is not a full-width encoding");
    a_r3_one_quadrant: assert ($countones({hit0, hit1, hit2, full_len}) == 1)
      else $error("R3 quadrant decode not one-hot");
  end
endmodule

// File: tb/cx_expander_tb.sv
`timescale 1ns/1ps
module cx_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] parcel = 16'h0000;
  logic        valid = 1'b0;
  logic [31:0] instr;
  logic        comp, ill;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam logic [31:0] NOP = 32'h0000_0013;

  always #2.5 clk = ~clk;

  cx_expander u_dut (.parcel_i(parcel), .valid_i(valid), .instr_o(instr),
                     .compressed_o(comp), .illegal_o(ill));

  // reference assemblers, built field by field
  function automatic logic [31:0] asm_i(int imm, int rs1, int f3, int rd, int op);
    logic [31:0] w, iv, r1, fv, dv, ov;
    iv = imm; r1 = rs1; fv = f3; dv = rd; ov = op;
    w = 32'd0;
    w[31:20] = iv[11:0]; w[19:15] = r1[4:0]; w[14:12] = fv[2:0];
    w[11:7] = dv[4:0]; w[6:0] = ov[6:0];
    return w;
  endfunction

  function automatic logic [31:0] asm_s(int imm, int rs2, int rs1, int f3);
    logic [31:0] w, iv, r1, r2, fv;
    iv = imm; r1 = rs1; r2 = rs2; fv = f3;
    w = 32'd0;
    w[31:25] = iv[11:5]; w[24:20] = r2[4:0]; w[19:15] = r1[4:0];
    w[14:12] = fv[2:0]; w[11:7] = iv[4:0]; w[6:0] = 7'h23;
    return w;
  endfunction

  function automatic logic [31:0] asm_r(int f7, int rs2, int rs1, int f3, int rd);
    logic [31:0] w, a, b, c, d, e;
    a = f7; b = rs2; c = rs1; d = f3; e = rd;
    w = 32'd0;
    w[31:25] = a[6:0]; w[24:20] = b[4:0]; w[19:15] = c[4:0];
    w[14:12] = d[2:0]; w[11:7] = e[4:0]; w[6:0] = 7'h33;
    return w;
  endfunction

  function automatic logic [31:0] asm_b(int off, int rs1, int f3);
    logic [31:0] w, o, r1, fv;
    o = off; r1 = rs1; fv = f3;
    w = 32'd0;
    w[31] = o[12]; w[30:25] = o[10:5]; w[19:15] = r1[4:0];
    w[14:12] = fv[2:0]; w[11:8] = o[4:1]; w[7] = o[11]; w[6:0] = 7'h63;
    return w;
  endfunction

  function automatic logic [31:0] asm_j(int off, int rd);
    logic [31:0] w, o, dv;
    o = off; dv = rd;
    w = 32'd0;
    w[31] = o[20]; w[30:21] = o[10:1]; w[20] = o[11]; w[19:12] = o[19:12];
    w[11:7] = dv[4:0]; w[6:0] = 7'h6F;
    return w;
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] p,
                       input logic v, input logic [31:0] ei, input logic ec, input logic eil);
    @(posedge clk); #1;
    parcel = p; valid = v;
    #2;
    checks++;
    if (instr !== ei || comp !== ec || ill !== eil) begin
      errors++;
      $display("FAIL %s %s parcel=%h: actual instr=%h c=%b ill=%b, expected instr=%h c=%b ill=%b",
               req, what, p, instr, comp, ill, ei, ec, eil);
    end
  endtask

  task automatic good(input string req, input string what, input logic [15:0] p, input logic [31:0] ei);
    check(req, what, p, 1'b1, ei, 1'b1, 1'b0);
  endtask

  task automatic bad(input string req, input string what, input logic [15:0] p);
    check(req, what, p, 1'b1, NOP, 1'b1, 1'b1);
  endtask

  task automatic t_idle;
    check("R1", "idle after reset", 16'h4501, 1'b0, NOP, 1'b0, 1'b0);
    check("R1", "idle zero parcel", 16'h0000, 1'b0, NOP, 1'b0, 1'b0);
  endtask

  task automatic t_pass;
    check("R2", "full length low", 16'h0513, 1'b1, 32'h0000_0513, 1'b0, 1'b0);
    check("R2", "full length ones", 16'hFFFF, 1'b1, 32'h0000_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_q0_imm;
    bad("R3", "all zero parcel", 16'h0000);
    good("R5", "sp add imm 100 x9", {3'b000, 2'b10, 4'b0001, 1'b1, 1'b0, 3'b001, 2'b00},
         asm_i(100, 2, 0, 9, 7'h13));
    bad("R5", "sp add zero imm", {3'b000, 8'd0, 3'b010, 2'b00});
  endtask

  task automatic t_q0_mem;
    good("R6", "R4 lw x10,108(x11)", {3'b010, 3'b101, 3'b011, 1'b1, 1'b1, 3'b010, 2'b00},
         asm_i(108, 11, 2, 10, 7'h03));
    good("R6", "R4 sw x15,8(x8)", {3'b110, 3'b001, 3'b000, 1'b0, 1'b0, 3'b111, 2'b00},
         asm_s(8, 15, 8, 2));
    good("R7", "lbu x13,23(x12)", {3'b001, 3'b011, 3'b100, 1'b1, 1'b1, 3'b101, 2'b00},
         asm_i(23, 12, 4, 13, 7'h03));
    good("R7", "sh x9,28(x14)", {3'b011, 3'b111, 3'b110, 1'b0, 1'b0, 3'b001, 2'b00},
         asm_s(28, 9, 14, 1));
    good("R7", "sb x15,31(x8)", {3'b101, 3'b111, 3'b000, 1'b1, 1'b1, 3'b111, 2'b00},
         asm_s(31, 15, 8, 0));
  endtask

  task automatic t_q0_andi;
    good("R8", "andi x10 -4", {3'b111, 1'b1, 2'b00, 3'b010, 5'b11100, 2'b00},
         asm_i(-4, 10, 7, 10, 7'h13));
    good("R8", "andi x15 15 ignored bits set", {3'b111, 1'b0, 2'b11, 3'b111, 5'b01111, 2'b00},
         asm_i(15, 15, 7, 15, 7'h13));
  endtask

  task automatic t_reserved;
    bad("R9", "quadrant 0 slot 100", {3'b100, 11'b01010101010, 2'b00});
    bad("R9", "quadrant 2 slot 111", {3'b111, 11'b00001000100, 2'b10});
  endtask

  task automatic t_q1_imm;
    good("R10", "addi x5 -1", {3'b000, 1'b1, 5'd5, 5'b11111, 2'b01}, asm_i(-1, 5, 0, 5, 7'h13));
    good("R10", "li x10 7", {3'b010, 1'b0, 5'd10, 5'd7, 2'b01}, asm_i(7, 0, 0, 10, 7'h13));
    good("R10", "lui x7 neg", {3'b011, 1'b1, 5'd7, 5'b00001, 2'b01}, 32'hFFFE_13B7);
    bad("R10", "lui zero", {3'b011, 1'b0, 5'd7, 5'd0, 2'b01});
    good("R10", "sp adjust -496", {3'b011, 1'b1, 5'd2, 5'b10000, 2'b01}, asm_i(-496, 2, 0, 2, 7'h13));
    bad("R10", "sp adjust zero", {3'b011, 1'b0, 5'd2, 5'd0, 2'b01});
  endtask

  task automatic t_q1_flow;
    good("R11", "j -2", {3'b101, 11'h7FF, 2'b01}, asm_j(-2, 0));
    good("R11", "jal +1024", {3'b001, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 2'b01},
         asm_j(1024, 1));
    good("R11", "beqz x9 -254", {3'b110, 1'b1, 2'b00, 3'b001, 2'b00, 2'b01, 1'b0, 2'b01},
         asm_b(-254, 9, 0));
    good("R11", "bnez x14 240", {3'b111, 1'b0, 2'b10, 3'b110, 2'b11, 2'b00, 1'b1, 2'b01},
         asm_b(240, 14, 1));
  endtask

  task automatic t_q1_alu;
    good("R12", "srli x8 3", {3'b100, 1'b0, 2'b00, 3'b000, 5'd3, 2'b01}, asm_i(3, 8, 5, 8, 7'h13));
    good("R12", "srai x15 31", {3'b100, 1'b0, 2'b01, 3'b111, 5'd31, 2'b01},
         asm_i(32'h41F, 15, 5, 15, 7'h13));
    bad("R12", "shift amount 33", {3'b100, 1'b1, 2'b00, 3'b000, 5'd1, 2'b01});
    good("R12", "andi x11 -32", {3'b100, 1'b1, 2'b10, 3'b011, 5'b00000, 2'b01},
         asm_i(-32, 11, 7, 11, 7'h13));
    good("R12", "sub x8 x9", {3'b100, 1'b0, 2'b11, 3'b000, 2'b00, 3'b001, 2'b01},
         asm_r(32, 9, 8, 0, 8));
    good("R12", "xor x13 x15", {3'b100, 1'b0, 2'b11, 3'b101, 2'b01, 3'b111, 2'b01},
         asm_r(0, 15, 13, 4, 13));
    good("R12", "or x10 x12", {3'b100, 1'b0, 2'b11, 3'b010, 2'b10, 3'b100, 2'b01},
         asm_r(0, 12, 10, 6, 10));
    bad("R12", "alu group bit12", {3'b100, 1'b1, 2'b11, 3'b000, 2'b00, 3'b000, 2'b01});
  endtask

  task automatic t_q2_sp;
    good("R13", "slli x6 5", {3'b000, 1'b0, 5'd6, 5'd5, 2'b10}, asm_i(5, 6, 1, 6, 7'h13));
    bad("R13", "slli shamt 37", {3'b000, 1'b1, 5'd6, 5'd5, 2'b10});
    good("R13", "lw x1,232(sp)", {3'b010, 1'b1, 5'd1, 3'b010, 2'b11, 2'b10}, asm_i(232, 2, 2, 1, 7'h03));
    bad("R13", "lw to x0", {3'b010, 1'b0, 5'd0, 5'd4, 2'b10});
    good("R13", "sw x31,76(sp)", {3'b110, 4'b0011, 2'b01, 5'd31, 2'b10}, asm_s(76, 31, 2, 2));
    good("R13", "lbu x20,37(sp)", {3'b001, 1'b0, 5'd20, 3'b101, 2'b10, 2'b10}, asm_i(37, 2, 4, 20, 7'h03));
    bad("R13", "lbu to x0", {3'b001, 1'b0, 5'd0, 5'd3, 2'b10});
    good("R13", "sh x9,126(sp)", {3'b011, 4'b1111, 2'b11, 5'd9, 2'b10}, asm_s(126, 9, 2, 1));
    good("R13", "sb x3,5(sp)", {3'b101, 4'b0101, 2'b00, 5'd3, 2'b10}, asm_s(5, 3, 2, 0));
  endtask

  task automatic t_q2_jump;
    good("R14", "jr x5", {3'b100, 1'b0, 5'd5, 5'd0, 2'b10}, asm_i(0, 5, 0, 0, 7'h67));
    bad("R14", "jr x0", {3'b100, 1'b0, 5'd0, 5'd0, 2'b10});
    good("R14", "mv x10 x11", {3'b100, 1'b0, 5'd10, 5'd11, 2'b10}, asm_r(0, 11, 0, 0, 10));
    good("R14", "ebreak", 16'h9002, 32'h0010_0073);
    good("R14", "jalr x1", {3'b100, 1'b1, 5'd1, 5'd0, 2'b10}, asm_i(0, 1, 0, 1, 7'h67));
    good("R14", "add x10 x11", {3'b100, 1'b1, 5'd10, 5'd11, 2'b10}, asm_r(0, 11, 10, 0, 10));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_pass();
    t_q0_imm();
    t_q0_mem();
    t_q0_andi();
    t_reserved();
    t_q1_imm();
    t_q1_flow();
    t_q1_alu();
    t_q2_sp();
    t_q2_jump();
    t_idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule